// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer with a small bank of 16-bit registers. It runs from a slow reference clock. A prescaler turns that clock into half-second ticks, and an 8-bit down-counter counts those ticks from a programmable reload value. Software keeps the timer from expiring by writing a two-word key to the service register. Any other pattern of writes leaves the count where it is.

When the counter runs out, the block takes one of two actions, chosen by a control bit. It either pulses an internal reset request, or it drives an active-low external reset line low and keeps it low until the block is reset. Software can also assert either reset directly. A pre-timeout interrupt can be programmed to fire a chosen number of half-seconds before expiry; its status bit is cleared by writing 1.

Once the timer is enabled it cannot be stopped. The two low-power suspend selections accept only the first control write after reset. A status bit records that the most recent reset came from an expiry. This bit survives the ordinary reset and is cleared only by a cold reset or by a software reset request.

Top module: `svc_watchdog`

## Requirements
- R1: After reset the control register (offset 0x0) reads 0x0030, and the interrupt-control register (offset 0x6) reads 0x0000. The outputs are irq=0, int_rst_req=0 and ext_rst_n=1.
- R2: Control bits [15:8] hold a reload value F. Timing starts at the write edge of a reload. Once enabled, the timer expires on the clock edge that lies (F+1)·REF_HZ/2 cycles later. While control bit 2 is 0, the timer never expires.
- R3: The counter reloads only when the service register (offset 0x2) receives 0x5555 and the next write to it is 0xAAAA. Any other value written after 0x5555 cancels the pending key without reloading. A repeated 0x5555 keeps the key pending.
- R4: Control bit 2 (enable) cannot be cleared by a write once it is 1.
- R5: Control bits 0 and 7 take their value from the first control write after reset. Later writes leave them unchanged.
- R6: While lp_mode=1 with control bit 0 set, the prescaler and counter are frozen. The same holds while wait_mode=1 with control bit 7 set. With the matching bit clear, the input has no effect.
- R7: On expiry with control bit 3 = 0, int_rst_req is high for exactly one cycle. With bit 3 = 1, ext_rst_n goes low instead, int_rst_req stays 0, and ext_rst_n stays low until reset.
- R8: Writing 0 to control bit 4 raises int_rst_req for one cycle, starting at the write edge. Bit 4 always reads 1.
- R9: ext_rst_n follows the last value written to control bit 5. Writing 0 drives the line low, and writing 1 releases it.
- R10: Status bit 1 (offset 0x4) becomes 1 on any expiry. It is cleared by a software reset request or by cold_rst, and it keeps its value through rst.
- R11: Interrupt-control bit 15 enables the pre-timeout interrupt and bits [7:0] hold a value P. While enabled, bit 14 sets when the counter decrements to P. Writing 1 to bit 14 clears it. irq equals bit 15 AND bit 14, delayed by one register.
- R12: A new reload value written while the timer runs does not change the count in progress. It takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| cold_rst | input | 1 | Synchronous power-on reset; also clears the cause bit |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered, valid the cycle after bus_rd |
| lp_mode | input | 1 | Chip is in low-power mode |
| wait_mode | input | 1 | Chip is in wait mode |
| irq | output | 1 | Pre-timeout interrupt |
| int_rst_req | output | 1 | Internal reset request pulse |
| ext_rst_n | output | 1 | External reset, active low |

## Verification
The assertions assume that software never issues two software-reset writes on consecutive cycles, and never places one in the cycle just before or after an internal expiry. Otherwise the one-cycle pulse property on int_rst_req would not hold. The stimulus services the timer immediately before every software-reset write, so no expiry can fall near it. Each write strobe lasts exactly one cycle. The bench also keeps rst high for several cycles at the start, so the past-value checks never see values from before the first clock edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W = 16;
  localparam logic [3:0] OFF_CTL = 4'h0;
  localparam logic [3:0] OFF_SVC = 4'h2;
  localparam logic [3:0] OFF_STA = 4'h4;
  localparam logic [3:0] OFF_ICR = 4'h6;
  localparam logic [REG_W-1:0] KEY_ARM  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_FIRE = 16'hAAAA;
  localparam int B_ZST = 0;
  localparam int B_EN  = 2;
  localparam int B_ACT = 3;
  localparam int B_SRS = 4;
  localparam int B_EXT = 5;
  localparam int B_WDW = 7;
  localparam int B_IE  = 15;
  localparam int B_IST = 14;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] pcnt;

  assign tick = run && (pcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear)  pcnt <= '0;
    else if (tick)     pcnt <= '0;
    else if (run)      pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             svc_wr,
  input  logic [REG_W-1:0] wdata,
  output logic             reload
);
  logic armed;

  assign reload = svc_wr && armed && (wdata == KEY_FIRE);

  always_ff @(posedge clk) begin
    if (rst)         armed <= 1'b0;
    else if (svc_wr) armed <= (wdata == KEY_ARM);
  end
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic [W-1:0] pre_val,
  output logic         expire,
  output logic         pre_hit,
  output logic [W-1:0] cnt
);
  logic [W-1:0] dec;

  assign dec     = cnt - 1'b1;
  assign expire  = tick && !load && (cnt == '0);
  assign pre_hit = tick && !load && (cnt != '0) && (dec == pre_val);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (expire) cnt <= load_val;
    else if (tick)   cnt <= dec;
  end
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import wdt_pkg::*;
#(
  parameter int REF_HZ = 32768,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cold_rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              lp_mode,
  input  logic              wait_mode,
  output logic              irq,
  output logic              int_rst_req,
  output logic              ext_rst_n
);
  localparam int HALF_DIV = REF_HZ / 2;

  logic [CNT_W-1:0] fld, pre, cnt;
  logic en, zst, wdw, wda, act, lock, ie, ist, cause, ext_hold;
  logic ctl_wr, svc_wr, icr_wr, srs_wr;
  logic run, tick, load, reload, expire, pre_hit;
  logic wda_nx, hold_nx;

  assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(OFF_CTL));
  assign svc_wr = bus_wr && (bus_addr == ADDR_W'(OFF_SVC));
  assign icr_wr = bus_wr && (bus_addr == ADDR_W'(OFF_ICR));
  assign srs_wr = ctl_wr && !bus_wdata[B_SRS];

  assign run  = en && !(lp_mode && zst) && !(wait_mode && wdw);
  assign load = reload || !en;

  wdt_keyseq u_key (
    .clk(clk), .rst(rst), .svc_wr(svc_wr), .wdata(bus_wdata), .reload(reload)
  );

  wdt_prescaler #(.DIV(HALF_DIV)) u_pre (
    .clk(clk), .rst(rst), .run(run), .clear(load), .tick(tick)
  );

  wdt_downcount #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(fld), .tick(tick),
    .pre_val(pre), .expire(expire), .pre_hit(pre_hit), .cnt(cnt)
  );

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      fld <= '0; en <= 1'b0; zst <= 1'b0; wdw <= 1'b0;
      wda <= 1'b1; act <= 1'b0; lock <= 1'b0;
    end else if (ctl_wr) begin
      fld <= bus_wdata[15:8];
      wda <= bus_wdata[B_EXT];
      act <= bus_wdata[B_ACT];
      en  <= en | bus_wdata[B_EN];
      if (!lock) begin
        zst  <= bus_wdata[B_ZST];
        wdw  <= bus_wdata[B_WDW];
        lock <= 1'b1;
      end
    end
  end

  // interrupt control
  always_ff @(posedge clk) begin
    if (rst) begin
      ie <= 1'b0; ist <= 1'b0; pre <= '0; irq <= 1'b0;
    end else begin
      if (icr_wr) begin
        ie  <= bus_wdata[B_IE];
        pre <= bus_wdata[7:0];
      end
      if (pre_hit && ie)                     ist <= 1'b1;
      else if (icr_wr && bus_wdata[B_IST])   ist <= 1'b0;
      irq <= ie && ist;
    end
  end

  // reset outputs
  assign wda_nx  = ctl_wr ? bus_wdata[B_EXT] : wda;
  assign hold_nx = ext_hold || (expire && act);

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_hold    <= 1'b0;
      ext_rst_n   <= 1'b1;
      int_rst_req <= 1'b0;
    end else begin
      ext_hold    <= hold_nx;
      ext_rst_n   <= wda_nx && !hold_nx;
      int_rst_req <= srs_wr || (expire && !act);
    end
  end

  // cause flag survives the ordinary reset
  always_ff @(posedge clk) begin
    if (cold_rst)    cause <= 1'b0;
    else if (expire) cause <= 1'b1;
    else if (srs_wr) cause <= 1'b0;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(OFF_CTL): bus_rdata <= {fld, wdw, 1'b0, wda, 1'b1, act, en, 1'b0, zst};
        ADDR_W'(OFF_STA): bus_rdata <= {14'b0, cause, 1'b0};
        ADDR_W'(OFF_ICR): bus_rdata <= {ie, ist, 6'b0, pre};
        default:          bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/svc_watchdog_chk.sv
module svc_watchdog_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             lock,
  input logic             zst,
  input logic             wdw,
  input logic             run,
  input logic             load,
  input logic [CNT_W-1:0] cnt,
  input logic             ext_hold,
  input logic             ext_rst_n,
  input logic             ie,
  input logic             irq,
  input logic             int_rst_req
);
  // R4
  en_sticky_chk: assert property (@(posedge clk) disable iff (rst) en |=> en);
  // R5
  susp_lock_chk: assert property (@(posedge clk) disable iff (rst) lock |=> $stable({zst, wdw}));
  // R6
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (rst) (!run && !load) |=> $stable(cnt));
  // R7
  ext_hold_chk: assert property (@(posedge clk) disable iff (rst) ext_hold |=> !ext_rst_n);
  // R8
  int_pulse_chk: assert property (@(posedge clk) disable iff (rst) int_rst_req |=> !int_rst_req);
  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst) $rose(irq) |-> $past(ie));
endmodule

bind svc_watchdog svc_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .lock(lock), .zst(zst), .wdw(wdw),
  .run(run), .load(load), .cnt(cnt), .ext_hold(ext_hold),
  .ext_rst_n(ext_rst_n), .ie(ie), .irq(irq), .int_rst_req(int_rst_req)
);

// File: tb/svc_watchdog_bench.sv
module svc_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REF_HZ = 8;
  localparam int HALF = REF_HZ / 2;

  logic clk = 1'b0, rst = 1'b1, cold_rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic lp_mode = 1'b0, wait_mode = 1'b0;
  logic irq, int_rst_req, ext_rst_n;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  svc_watchdog #(.REF_HZ(REF_HZ)) u_svc_watchdog (
    .clk(clk), .rst(rst), .cold_rst(cold_rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lp_mode(lp_mode), .wait_mode(wait_mode), .irq(irq),
    .int_rst_req(int_rst_req), .ext_rst_n(ext_rst_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1; bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic service();
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
  endtask

  // sel 0: int_rst_req, 1: irq, 2: ext_rst_n low; counts edges until seen
  task automatic meas(input int sel, input int lim, inout int n, output bit saw_int);
    bit hit;
    saw_int = 0;
    do begin
      @(posedge clk); #1; n++;
      if (int_rst_req) saw_int = 1;
      hit = (sel == 0) ? int_rst_req : (sel == 1) ? irq : !ext_rst_n;
    end while (!hit && n < lim);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int n;
    bit si;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0; cold_rst = 1'b0;
    #1;
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 int_rst_req", {15'b0, int_rst_req}, 16'h0);
    chk("R1 ext_rst_n", {15'b0, ext_rst_n}, 16'h1);
    rd(4'h0, d); chk("R1 ctl", d, 16'h0030);
    rd(4'h6, d); chk("R1 icr", d, 16'h0000);
    rd(4'h4, d); chk("R10 cold status", d, 16'h0000);

    // R5: first write latches bit0=1, bit7=0
    wr(4'h0, 16'h0331); rd(4'h0, d); chk("R5 first write", d, 16'h0331);
    wr(4'h0, 16'h03B0); rd(4'h0, d); chk("R5 locked bits", d, 16'h0331);

    // R2: disabled timer never expires
    service(); n = 0; meas(0, 60, n, si);
    chk("R2 disabled no expiry", {15'b0, si}, 16'h0);

    // R4: enable, then attempt to clear
    wr(4'h0, 16'h0335); wr(4'h0, 16'h0331);
    rd(4'h0, d); chk("R4 enable sticky", d, 16'h0335);

    // R2 sweep of reload values
    for (int f = 0; f < 8; f++) begin
      wr(4'h0, 16'(f << 8) | 16'h0035);
      service(); n = 0; meas(0, 200, n, si);
      chk("R2 timeout cycles", 16'(n), 16'((f + 1) * HALF));
    end
    @(posedge clk); #1;
    chk("R7 one-cycle pulse", {15'b0, int_rst_req}, 16'h0);
    rd(4'h4, d); chk("R10 cause set", d, 16'h0002);

    // R12: change while running
    wr(4'h0, 16'h0735); service();
    wr(4'h0, 16'h0135); n = 0; meas(0, 200, n, si);
    chk("R12 old value in force", 16'(n), 16'(8 * HALF - 1));
    service(); n = 0; meas(0, 200, n, si);
    chk("R12 new value on reload", 16'(2 * HALF), 16'(n));
    wr(4'h0, 16'h0735);

    // R3: broken key after 0x5555 does not reload
    service(); wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    n = 0; meas(0, 200, n, si);
    chk("R3 broken key", 16'(n), 16'(8 * HALF - 3));
    service(); wr(4'h2, 16'h5555); wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    n = 0; meas(0, 200, n, si);
    chk("R3 repeated arm", 16'(n), 16'(8 * HALF));
    service(); wr(4'h2, 16'hAAAA); n = 0; meas(0, 200, n, si);
    chk("R3 lone fire key", 16'(n), 16'(8 * HALF - 1));

    // R6: low-power freeze (bit0 set), wait has no effect (bit7 clear)
    wr(4'h2, 16'h5555); lp_mode = 1'b1; wr(4'h2, 16'hAAAA);
    repeat (19) @(posedge clk); #1; lp_mode = 1'b0;
    n = 19; meas(0, 300, n, si);
    chk("R6 lp freeze", 16'(n), 16'(8 * HALF + 19));
    wait_mode = 1'b1; service(); n = 0; meas(0, 200, n, si);
    chk("R6 wait ignored", 16'(n), 16'(8 * HALF));
    wait_mode = 1'b0;

    // R11: pre-timeout interrupt at P=2
    wr(4'h6, 16'h8002); service(); n = 0; meas(1, 200, n, si);
    chk("R11 irq timing", 16'(n), 16'((7 - 2) * HALF + 1));
    rd(4'h6, d); chk("R11 status set", d, 16'hC002);
    wr(4'h6, 16'hC002); @(posedge clk); #1;
    chk("R11 irq cleared", {15'b0, irq}, 16'h0);
    rd(4'h6, d); chk("R11 w1c", d, 16'h8002);
    wr(4'h6, 16'h0000);

    // R8 / R10: software reset
    service(); wr(4'h0, 16'h0725);
    chk("R8 srs pulse", {15'b0, int_rst_req}, 16'h1);
    @(posedge clk); #1;
    chk("R8 srs one cycle", {15'b0, int_rst_req}, 16'h0);
    rd(4'h4, d); chk("R10 cleared by srs", d, 16'h0000);
    rd(4'h0, d); chk("R8 srs reads 1", d, 16'h0735);

    // R9: direct external reset
    service(); wr(4'h0, 16'h0715);
    chk("R9 ext low", {15'b0, ext_rst_n}, 16'h0);
    wr(4'h0, 16'h0735);
    chk("R9 ext released", {15'b0, ext_rst_n}, 16'h1);

    // R7: external action on expiry
    wr(4'h0, 16'h073D); service(); n = 0; meas(2, 200, n, si);
    chk("R7 ext timing", 16'(n), 16'(8 * HALF));
    chk("R7 no int req", {15'b0, si}, 16'h0);
    repeat (50) @(posedge clk); #1;
    chk("R7 ext held", {15'b0, ext_rst_n}, 16'h0);
    rd(4'h4, d); chk("R10 cause ext", d, 16'h0002);

    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; #1;
    chk("R7 released by rst", {15'b0, ext_rst_n}, 16'h1);
    rd(4'h4, d); chk("R10 kept through rst", d, 16'h0002);
    rd(4'h0, d); chk("R1 ctl after rst", d, 16'h0030);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule